// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block moves a processor core into an exception handler. A pipeline stage raises a synchronous exception request carrying a five-bit cause code. Two level-sensitive lines signal a pending external-device interrupt and a pending tick-timer interrupt. Each cycle the block picks one candidate cause and holds it as a pending exception. When the pipeline asserts the take strobe, the block commits the whole entry sequence on a single clock edge. It saves the return address, the prior status word and, for an illegal instruction, the faulting address. It rewrites the status and power-management words, invalidates the load-link reservation and presents the handler vector as the new program counter.

The return address depends on the cause and on whether the faulting instruction sat in a branch delay slot. The handler vector is the cause code shifted left by eight bits. It is OR-ed with an optional vector base and with a high-region prefix. A cause code outside the defined range does not vector. It raises a one-cycle abort pulse and leaves every saved register unchanged. Instruction fetch, address translation and the return-from-exception path are outside this block.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A request is latched as pending on the clock edge where it is presented. A take strobe commits the pending cause on the next edge, and the vector-valid output is high for exactly that one cycle. The commit clears the pending cause. A take strobe with nothing pending changes no output.
- R2: The saved exception PC is the current PC. For the system-call cause (code 12) it is the current PC plus 4.
- R3: When the delay-slot input is high at commit, the saved PC is reduced by 4 and status bit 13 (delay-slot exception) is set. Otherwise bit 13 is cleared. A system call in a delay slot therefore saves the current PC unchanged.
- R4: For the illegal-instruction cause (code 7), the fault-address output is loaded with the current PC. All other causes leave it unchanged.
- R5: The saved status output equals the status input as it was at commit, before any modification.
- R6: The new status word clears bit 5 (data MMU enable), bit 6 (instruction MMU enable), bit 2 (interrupt enable) and bit 1 (tick enable). It sets bit 0 (supervisor mode). Bits 14 and the rest outside these and bit 13 pass through unchanged.
- R7: The new power-management word clears bit 4 (doze enable) and bit 5 (sleep enable), and keeps every other bit.
- R8: The reservation address output becomes all ones on every valid commit.
- R9: The new PC is the code shifted left by 8. It is OR-ed with the vector base input when the base-present input is high, and with 0xF0000000 when status bit 14 (high prefix) is set.
- R10: The external line (code 8) is accepted only while status bit 2 is set. The tick line (code 5) is accepted only while status bit 1 is set. When both are accepted in the same cycle, the tick cause wins.
- R11: A synchronous request beats any interrupt in the same cycle. It also replaces an interrupt that is already pending but not yet taken.
- R12: A committed code of 0 or 15 and above raises the abort output for one cycle. It gives no vector-valid pulse and leaves the PC, saved PC and status outputs unchanged.
- R13: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_req | input | 1 | Synchronous exception request |
| sync_code | input | 5 | Cause code of the synchronous request |
| ext_irq | input | 1 | External-device interrupt pending |
| tick_irq | input | 1 | Tick-timer interrupt pending |
| take | input | 1 | Commit the pending exception |
| cur_pc | input | 32 | PC of the instruction being excepted |
| dslot | input | 1 | Instruction is in a branch delay slot |
| sr_in | input | 16 | Current status word |
| pmr_in | input | 8 | Current power-management word |
| vec_base | input | 32 | Vector base value |
| base_en | input | 1 | Vector base present |
| epc_o | output | 32 | Saved exception PC |
| eear_o | output | 32 | Saved fault address |
| esr_o | output | 16 | Saved status word |
| sr_o | output | 16 | Status word after entry |
| pmr_o | output | 8 | Power-management word after entry |
| lock_o | output | 32 | Load-link reservation address |
| pc_o | output | 32 | Handler vector (new PC) |
| vec_vld_o | output | 1 | One-cycle pulse: entry committed |
| abort_o | output | 1 | One-cycle pulse: undefined cause committed |

## Verification
The collision that matters is a synchronous request and an interrupt arriving together. The bench provokes it twice. In the first case the tick line is enabled and high in the very cycle a code-6 request arrives. In the second an enabled tick is already pending and a code-3 request arrives one cycle later. Both cases are judged only at the ports: the vector after the take strobe must carry the synchronous code, not 0x500. A second overlap inside the sequencing itself is a system call in a delay slot, where the +4 and -4 adjustments must cancel exactly.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/1ps
package exc_entry_pkg;
    localparam int CODE_W     = 5;
    localparam int CODE_COUNT = 15;
    localparam int VEC_SHIFT  = 8;

    localparam logic [CODE_W-1:0] C_NONE    = 5'd0;
    localparam logic [CODE_W-1:0] C_TICK    = 5'd5;
    localparam logic [CODE_W-1:0] C_ILLEGAL = 5'd7;
    localparam logic [CODE_W-1:0] C_EXTINT  = 5'd8;
    localparam logic [CODE_W-1:0] C_SYSCALL = 5'd12;

    // status word bit positions
    localparam int SB_SUPV = 0;
    localparam int SB_TICK = 1;
    localparam int SB_IRQ  = 2;
    localparam int SB_DMMU = 5;
    localparam int SB_IMMU = 6;
    localparam int SB_DSX  = 13;
    localparam int SB_HIGH = 14;

    // power-management word bit positions
    localparam int PB_DOZE  = 4;
    localparam int PB_SLEEP = 5;
endpackage

// File: rtl/exc_arbiter.sv
`timescale 1ns/1ps
module exc_arbiter
    import exc_entry_pkg::*;
(
    input  logic              sync_req,
    input  logic [CODE_W-1:0] sync_code,
    input  logic              ext_irq,
    input  logic              tick_irq,
    input  logic              irq_en,
    input  logic              tick_en,
    output logic              cand_vld,
    output logic              cand_sync,
    output logic [CODE_W-1:0] cand_code
);
    always_comb begin
        cand_vld  = 1'b0;
        cand_sync = 1'b0;
        cand_code = C_NONE;
        if (sync_req) begin
            cand_vld  = 1'b1;
            cand_sync = 1'b1;
            cand_code = sync_code;
        end else if (tick_irq && tick_en) begin
            cand_vld  = 1'b1;
            cand_code = C_TICK;
        end else if (ext_irq && irq_en) begin
            cand_vld  = 1'b1;
            cand_code = C_EXTINT;
        end
    end
endmodule

// File: rtl/exc_ctx_calc.sv
`timescale 1ns/1ps
module exc_ctx_calc
    import exc_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int SR_W       = 16,
    parameter int PMR_W      = 8,
    parameter int INSN_BYTES = 4
) (
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   pc,
    input  logic              in_dslot,
    input  logic [SR_W-1:0]   sr_cur,
    input  logic [PMR_W-1:0]  pmr_cur,
    output logic              code_ok,
    output logic              is_illegal,
    output logic [XLEN-1:0]   epc,
    output logic [SR_W-1:0]   sr_new,
    output logic [PMR_W-1:0]  pmr_new
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    always_comb begin
        code_ok    = (code != C_NONE) && (int'(code) < CODE_COUNT);
        is_illegal = (code == C_ILLEGAL);

        epc = pc;
        if (code == C_SYSCALL) epc = epc + STEP;
        if (in_dslot)          epc = epc - STEP;

        sr_new          = sr_cur;
        sr_new[SB_DMMU] = 1'b0;
        sr_new[SB_IMMU] = 1'b0;
        sr_new[SB_IRQ]  = 1'b0;
        sr_new[SB_TICK] = 1'b0;
        sr_new[SB_SUPV] = 1'b1;
        sr_new[SB_DSX]  = in_dslot;

        pmr_new           = pmr_cur;
        pmr_new[PB_DOZE]  = 1'b0;
        pmr_new[PB_SLEEP] = 1'b0;
    end
endmodule

// File: rtl/exc_vector_gen.sv
`timescale 1ns/1ps
module exc_vector_gen
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   base,
    input  logic              base_en,
    input  logic              high_en,
    output logic [XLEN-1:0]   vec
);
    localparam logic [XLEN-1:0] HIGH_PREFIX = {4'hF, {(XLEN-4){1'b0}}};

    always_comb begin
        vec = XLEN'(code) << VEC_SHIFT;
        if (base_en) vec = vec | base;
        if (high_en) vec = vec | HIGH_PREFIX;
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int SR_W  = 16,
    parameter int PMR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_req,
    input  logic [CODE_W-1:0] sync_code,
    input  logic              ext_irq,
    input  logic              tick_irq,
    input  logic              take,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              dslot,
    input  logic [SR_W-1:0]   sr_in,
    input  logic [PMR_W-1:0]  pmr_in,
    input  logic [XLEN-1:0]   vec_base,
    input  logic              base_en,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   eear_o,
    output logic [SR_W-1:0]   esr_o,
    output logic [SR_W-1:0]   sr_o,
    output logic [PMR_W-1:0]  pmr_o,
    output logic [XLEN-1:0]   lock_o,
    output logic [XLEN-1:0]   pc_o,
    output logic              vec_vld_o,
    output logic              abort_o
);
    typedef struct packed {
        logic              pend_vld;
        logic [CODE_W-1:0] pend_code;
        logic [XLEN-1:0]   epc;
        logic [XLEN-1:0]   eear;
        logic [SR_W-1:0]   esr;
        logic [SR_W-1:0]   sr;
        logic [PMR_W-1:0]  pmr;
        logic [XLEN-1:0]   lock;
        logic [XLEN-1:0]   pc;
        logic              vec_vld;
        logic              abort;
    } ent_state_t;

    ent_state_t st_d, st_q;

    logic              cand_vld, cand_sync;
    logic [CODE_W-1:0] cand_code;
    logic              code_ok, is_illegal;
    logic [XLEN-1:0]   epc_calc, vec_calc;
    logic [SR_W-1:0]   sr_calc;
    logic [PMR_W-1:0]  pmr_calc;

    exc_arbiter u_arb (
        .sync_req  (sync_req),
        .sync_code (sync_code),
        .ext_irq   (ext_irq),
        .tick_irq  (tick_irq),
        .irq_en    (sr_in[SB_IRQ]),
        .tick_en   (sr_in[SB_TICK]),
        .cand_vld  (cand_vld),
        .cand_sync (cand_sync),
        .cand_code (cand_code)
    );

    exc_ctx_calc #(.XLEN(XLEN), .SR_W(SR_W), .PMR_W(PMR_W)) u_ctx (
        .code       (st_q.pend_code),
        .pc         (cur_pc),
        .in_dslot   (dslot),
        .sr_cur     (sr_in),
        .pmr_cur    (pmr_in),
        .code_ok    (code_ok),
        .is_illegal (is_illegal),
        .epc        (epc_calc),
        .sr_new     (sr_calc),
        .pmr_new    (pmr_calc)
    );

    exc_vector_gen #(.XLEN(XLEN)) u_vec (
        .code    (st_q.pend_code),
        .base    (vec_base),
        .base_en (base_en),
        .high_en (sr_in[SB_HIGH]),
        .vec     (vec_calc)
    );

    always_comb begin
        st_d         = st_q;
        st_d.vec_vld = 1'b0;
        st_d.abort   = 1'b0;
        if (take && st_q.pend_vld) begin
            if (code_ok) begin
                st_d.epc     = epc_calc;
                if (is_illegal) st_d.eear = cur_pc;
                st_d.esr     = sr_in;
                st_d.sr      = sr_calc;
                st_d.pmr     = pmr_calc;
                st_d.lock    = '1;
                st_d.pc      = vec_calc;
                st_d.vec_vld = 1'b1;
            end else begin
                st_d.abort   = 1'b1;
            end
            st_d.pend_vld  = cand_vld;
            st_d.pend_code = cand_code;
        end else if (cand_vld && (!st_q.pend_vld || cand_sync)) begin
            st_d.pend_vld  = 1'b1;
            st_d.pend_code = cand_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign epc_o     = st_q.epc;
    assign eear_o    = st_q.eear;
    assign esr_o     = st_q.esr;
    assign sr_o      = st_q.sr;
    assign pmr_o     = st_q.pmr;
    assign lock_o    = st_q.lock;
    assign pc_o      = st_q.pc;
    assign vec_vld_o = st_q.vec_vld;
    assign abort_o   = st_q.abort;
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
`timescale 1ns/1ps
module exc_entry_ctrl_chk
    import exc_entry_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int SR_W  = 16,
    parameter int PMR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             take,
    input logic [SR_W-1:0]  sr_in,
    input logic [SR_W-1:0]  esr_o,
    input logic [SR_W-1:0]  sr_o,
    input logic [PMR_W-1:0] pmr_o,
    input logic [XLEN-1:0]  lock_o,
    input logic [XLEN-1:0]  pc_o,
    input logic             vec_vld_o,
    input logic             abort_o
);
    localparam logic [SR_W-1:0] SR_OFF =
        SR_W'((1 << SB_DMMU) | (1 << SB_IMMU) | (1 << SB_IRQ) | (1 << SB_TICK));
    localparam logic [PMR_W-1:0] PMR_OFF = PMR_W'((1 << PB_DOZE) | (1 << PB_SLEEP));
    localparam logic [XLEN-1:0] LOW_MASK = XLEN'((1 << VEC_SHIFT) - 1);

    assert_entry_needs_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o |-> $past(take));
    assert_esr_prior_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o |-> (esr_o == $past(sr_in)));
    assert_sr_rewrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o |-> (((sr_o & SR_OFF) == '0) && sr_o[SB_SUPV]));
    assert_pmr_rewrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o |-> ((pmr_o & PMR_OFF) == '0));
    assert_lock_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o |-> (lock_o == '1));
    assert_vector_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o |-> ((pc_o & LOW_MASK) == '0));
    assert_single_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_vld_o && abort_o));
    assert_abort_holds_pc_R12: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (pc_o == $past(pc_o)));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.XLEN(XLEN), .SR_W(SR_W), .PMR_W(PMR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .sr_in     (sr_in),
    .esr_o     (esr_o),
    .sr_o      (sr_o),
    .pmr_o     (pmr_o),
    .lock_o    (lock_o),
    .pc_o      (pc_o),
    .vec_vld_o (vec_vld_o),
    .abort_o   (abort_o)
);

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_req = 1'b0;
    logic [4:0]  sync_code = '0;
    logic        ext_irq = 1'b0;
    logic        tick_irq = 1'b0;
    logic        take = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        dslot = 1'b0;
    logic [15:0] sr_in = '0;
    logic [7:0]  pmr_in = '0;
    logic [31:0] vec_base = '0;
    logic        base_en = 1'b0;
    logic [31:0] epc_o, eear_o, lock_o, pc_o;
    logic [15:0] esr_o, sr_o;
    logic [7:0]  pmr_o;
    logic        vec_vld_o, abort_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    exc_entry_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .sync_code(sync_code),
        .ext_irq(ext_irq), .tick_irq(tick_irq), .take(take), .cur_pc(cur_pc),
        .dslot(dslot), .sr_in(sr_in), .pmr_in(pmr_in), .vec_base(vec_base),
        .base_en(base_en), .epc_o(epc_o), .eear_o(eear_o), .esr_o(esr_o),
        .sr_o(sr_o), .pmr_o(pmr_o), .lock_o(lock_o), .pc_o(pc_o),
        .vec_vld_o(vec_vld_o), .abort_o(abort_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_sr(input logic [15:0] s, input logic ds);
        logic [15:0] r;
        r = (s & ~16'h0066) | 16'h0001;
        r[13] = ds;
        return r;
    endfunction

    // request in one cycle, take in the next; outputs valid after return
    task automatic sync_then_take(input logic [4:0] code, input logic [31:0] pc,
                                  input logic ds, input logic [15:0] sr,
                                  input logic [7:0] pmr, input logic ben,
                                  input logic [31:0] base);
        @(negedge clk);
        sync_req = 1'b1; sync_code = code;
        @(negedge clk);
        sync_req = 1'b0; take = 1'b1;
        cur_pc = pc; dslot = ds; sr_in = sr; pmr_in = pmr; base_en = ben; vec_base = base;
        @(negedge clk);
        take = 1'b0;
    endtask

    task automatic t_reset;
        chk("R13 pc", pc_o, 32'h0);
        chk("R13 epc", epc_o, 32'h0);
        chk("R13 lock", lock_o, 32'h0);
        chk("R13 flags", {30'h0, vec_vld_o, abort_o}, 32'h0);
    endtask

    task automatic t_syscall;
        sync_then_take(5'd12, 32'h2000, 1'b0, 16'h0000, 8'h00, 1'b0, 32'h0);
        chk("R1 vec_vld pulse", {31'h0, vec_vld_o}, 32'h1);
        chk("R2 syscall epc", epc_o, 32'h2004);
        chk("R9 syscall vector", pc_o, 32'h0000_0C00);
        @(negedge clk);
        chk("R1 pulse ends", {31'h0, vec_vld_o}, 32'h0);
        take = 1'b1;
        @(negedge clk);
        take = 1'b0;
        chk("R1 take with nothing pending", {31'h0, vec_vld_o}, 32'h0);
        chk("R1 pc unchanged", pc_o, 32'h0000_0C00);
    endtask

    task automatic t_illegal_dslot;
        sync_then_take(5'd7, 32'h1000, 1'b1, 16'h0004, 8'h00, 1'b0, 32'h0);
        chk("R3 dslot epc", epc_o, 32'h0FFC);
        chk("R4 illegal eear", eear_o, 32'h1000);
        chk("R3 dsx set", {16'h0, sr_o}, {16'h0, exp_sr(16'h0004, 1'b1)});
        chk("R9 illegal vector", pc_o, 32'h0000_0700);
        sync_then_take(5'd12, 32'h3000, 1'b1, 16'h0000, 8'h00, 1'b0, 32'h0);
        chk("R3 syscall in dslot epc", epc_o, 32'h3000);
        sync_then_take(5'd2, 32'h4000, 1'b0, 16'h2000, 8'h00, 1'b0, 32'h0);
        chk("R4 eear unchanged", eear_o, 32'h1000);
        chk("R3 dsx cleared", {31'h0, sr_o[13]}, 32'h0);
        chk("R2 plain epc", epc_o, 32'h4000);
    endtask

    task automatic t_status_rewrite;
        sync_then_take(5'd6, 32'h5000, 1'b0, 16'hFFFF, 8'hFF, 1'b0, 32'h0);
        chk("R5 esr", {16'h0, esr_o}, 32'h0000_FFFF);
        chk("R6 sr", {16'h0, sr_o}, 32'h0000_DF99);
        chk("R7 pmr", {24'h0, pmr_o}, 32'h0000_00CF);
        chk("R8 lock", lock_o, 32'hFFFF_FFFF);
        chk("R9 high prefix", pc_o, 32'hF000_0600);
    endtask

    task automatic t_vector_base;
        sync_then_take(5'd14, 32'h100, 1'b0, 16'h0000, 8'h00, 1'b1, 32'h0001_0000);
        chk("R9 base", pc_o, 32'h0001_0E00);
        sync_then_take(5'd14, 32'h100, 1'b0, 16'h4000, 8'h00, 1'b1, 32'h0001_0000);
        chk("R9 base and prefix", pc_o, 32'hF001_0E00);
        sync_then_take(5'd14, 32'h100, 1'b0, 16'h0000, 8'h00, 1'b0, 32'h0001_0000);
        chk("R9 base ignored", pc_o, 32'h0000_0E00);
    endtask

    task automatic irq_then_take(input logic ext, input logic tick, input logic [15:0] sr);
        @(negedge clk);
        ext_irq = ext; tick_irq = tick; sr_in = sr; base_en = 1'b0; dslot = 1'b0;
        @(negedge clk);
        ext_irq = 1'b0; tick_irq = 1'b0; take = 1'b1;
        @(negedge clk);
        take = 1'b0;
    endtask

    task automatic t_interrupts;
        irq_then_take(1'b1, 1'b0, 16'h0004);
        chk("R10 ext enabled vld", {31'h0, vec_vld_o}, 32'h1);
        chk("R10 ext vector", pc_o, 32'h0000_0800);
        irq_then_take(1'b1, 1'b1, 16'h0006);
        chk("R10 tick wins", pc_o, 32'h0000_0500);
        irq_then_take(1'b1, 1'b1, 16'h0004);
        chk("R10 tick masked, ext taken", pc_o, 32'h0000_0800);
        irq_then_take(1'b1, 1'b0, 16'h0002);
        chk("R10 ext masked no entry", {31'h0, vec_vld_o}, 32'h0);
        chk("R10 ext masked pc held", pc_o, 32'h0000_0800);
    endtask

    task automatic t_sync_priority;
        @(negedge clk);
        sync_req = 1'b1; sync_code = 5'd6; tick_irq = 1'b1; sr_in = 16'h0002;
        @(negedge clk);
        sync_req = 1'b0; tick_irq = 1'b0; take = 1'b1;
        @(negedge clk);
        take = 1'b0;
        chk("R11 sync beats tick", pc_o, 32'h0000_0600);
        @(negedge clk);
        tick_irq = 1'b1; sr_in = 16'h0002;
        @(negedge clk);
        tick_irq = 1'b0; sync_req = 1'b1; sync_code = 5'd3;
        @(negedge clk);
        sync_req = 1'b0; take = 1'b1;
        @(negedge clk);
        take = 1'b0;
        chk("R11 sync replaces pending tick", pc_o, 32'h0000_0300);
    endtask

    task automatic t_bad_code;
        logic [31:0] pc_before, epc_before;
        pc_before  = pc_o;
        epc_before = epc_o;
        sync_then_take(5'd0, 32'h9000, 1'b0, 16'h0004, 8'h00, 1'b0, 32'h0);
        chk("R12 code0 abort", {30'h0, vec_vld_o, abort_o}, 32'h1);
        chk("R12 code0 pc held", pc_o, pc_before);
        chk("R12 code0 epc held", epc_o, epc_before);
        sync_then_take(5'd15, 32'h9000, 1'b0, 16'h0004, 8'h00, 1'b0, 32'h0);
        chk("R12 code15 abort", {30'h0, vec_vld_o, abort_o}, 32'h1);
        chk("R12 code15 pc held", pc_o, pc_before);
        @(negedge clk);
        chk("R12 abort one cycle", {31'h0, abort_o}, 32'h0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_syscall();
        t_illegal_dslot();
        t_status_rewrite();
        t_vector_base();
        t_interrupts();
        t_sync_priority();
        t_bad_code();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule